// File: doc/BRIEF.md
# Ring-Buffer Tag Chain Walker

This block steps a DMA channel through a chain of 128-bit descriptors ("tags") that sit in a ring buffer. The ring is given by a base address and a byte-size mask. For each tag fetched over a simple request/valid read port, the block decodes a type, a quadword count and an address. From these it produces the address of the data burst and the address of the next tag. Every address that lies inside the ring is folded back into it as base plus (address AND mask). One quadword is 16 bytes.

A producer tops up a signed credit counter of quadwords present in the ring. Each tag fetch costs one credit, and each consumed data quadword costs one more. If the walker needs a tag while the credit is zero or negative, it does not fetch. It raises a stall pulse and waits until credit arrives. The downstream mover reports the quadwords it has taken. The walker advances the data address, which wraps at the ring end, and reports the segment length that fits before the ring end. When a chain-ending tag has been fully drained, the walker pulses `done`, goes inactive and clears the credit counter.

Top module: `ring_chain_walker`

## Requirements
- R1: After reset the walker is inactive, with `tagReq`, `done` and `stallIrq` low, `availQwc` zero and `dataQwc` zero.
- R2: In tag word 0, bits 30:28 are the type, bits 15:0 the quadword count and bits 31:16 are copied to `ctrlUpper`. Tag word 1 is the address field. A tag is taken in a cycle where `tagReq` and `tagValid` are both high, and the outputs show the decoded values on the next cycle.
- R3: A ring fold is `ringBase + (x & ringMask)`. Every tag-relative address (tag+16, and data+qwc*16 after it) is folded.
- R4: Type 0 takes data from the address field, sets the next tag to fold(tag+16) and ends the chain.
- R5: Type 1 sets data to fold(tag+16) and the next tag to fold(data+qwc*16), then continues. Type 7 computes the same addresses and ends the chain.
- R6: Type 2 sets data to fold(tag+16) and the next tag to the address field, without folding.
- R7: Types 3 and 4 take data from the address field and set the next tag to fold(tag+16). Data that comes from the address field is not folded as it advances.
- R8: A tag with bit 31 set ends the chain after its data when `tagIrqEn` was high at `start`. If `tagIrqEn` was low, the bit has no effect.
- R9: `availQwc` rises by `addQwc` on `addValid`, falls by 1 for each tag taken and falls by the quadwords consumed. It may go negative.
- R10: When a tag is needed and `availQwc` <= 0, `stallIrq` pulses for one cycle and `tagReq` stays low. Fetching resumes once credit is positive.
- R11: When a chain-ending tag has `dataQwc` = 0, `done` pulses for one cycle. On the next cycle `active` is low and `availQwc` is zero.
- R12: `segQwc` is the part of `dataQwc` that fits before `ringBase+ringMask+1` when the data lies in the ring, otherwise `dataQwc`. Consuming past the ring end continues at `ringBase`.
- R13: Types 5 and 6 end the chain with a count of zero and leave both addresses unchanged.
- R14: A consume of n quadwords (clamped to `dataQwc`) lowers `dataQwc` by n and advances `dataAddr` by 16n on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBase | input | AW | Ring start address |
| ringMask | input | AW | Ring byte-size mask (size-1) |
| start | input | 1 | Begin a chain while idle |
| startTagAddr | input | AW | First tag address |
| tagIrqEn | input | 1 | Enable tag bit 31 as chain end, latched at start |
| addValid | input | 1 | Producer added quadwords |
| addQwc | input | QCW | Quadwords added |
| consumeValid | input | 1 | Mover took data quadwords |
| consumeQwc | input | QCW | Quadwords taken |
| tagReq | output | 1 | Tag read request |
| tagAddr | output | AW | Current/next tag address |
| tagValid | input | 1 | Tag words present |
| tagWord0 | input | 32 | Tag type, flags and count |
| tagWord1 | input | 32 | Tag address field |
| dataAddr | output | AW | Current data address |
| dataQwc | output | QCW | Quadwords left in this tag |
| segQwc | output | QCW | Quadwords before ring end |
| ctrlUpper | output | 16 | Upper control half from the last tag |
| availQwc | output | AVW | Signed credit counter |
| active | output | 1 | Chain in progress |
| done | output | 1 | Chain finished pulse |
| stallIrq | output | 1 | Empty-ring stall pulse |

## Verification
A wrong fold or a wrong type decode shows up at the very next tag fetch, because `tagAddr` then carries an address the scoreboard did not expect, or it shows on `dataAddr` in the cycle after the tag is taken. Credit bookkeeping errors show as a stall that comes too early or too late, or as a non-zero counter after `done`. Those appear within a cycle or two of the consume that crosses zero. End-of-chain mistakes show as a missing `done` or as an extra fetch after an ending tag.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_STALL
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic takeTag;
    logic takeData;
    logic finish;
  } walkStrobe_t;

  localparam logic [2:0] KIND_REFE = 3'd0;
  localparam logic [2:0] KIND_CNT  = 3'd1;
  localparam logic [2:0] KIND_NEXT = 3'd2;
  localparam logic [2:0] KIND_REF  = 3'd3;
  localparam logic [2:0] KIND_REFS = 3'd4;
  localparam logic [2:0] KIND_END  = 3'd7;

  localparam int QW_BYTES_LOG2 = 4;
endpackage

// File: rtl/ring_walk_dp.sv
module ring_walk_dp
  import ring_walk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int QCW = 16,
  parameter int AVW = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkStrobe_t           stb,
  input  logic [AW-1:0]         ringBase,
  input  logic [AW-1:0]         ringMask,
  input  logic [AW-1:0]         startTagAddr,
  input  logic                  tagIrqEn,
  input  logic [31:0]           tagWord0,
  input  logic [31:0]           tagWord1,
  input  logic                  addValid,
  input  logic [QCW-1:0]        addQwc,
  input  logic [QCW-1:0]        consumeQwc,
  output logic [AW-1:0]         tagAddr,
  output logic [AW-1:0]         dataAddr,
  output logic [QCW-1:0]        dataQwc,
  output logic [QCW-1:0]        segQwc,
  output logic [15:0]           ctrlUpper,
  output logic signed [AVW-1:0] availQwc,
  output logic                  availPos,
  output logic                  qwcZero,
  output logic                  endPending
);
  localparam logic [AW-1:0] QW_STEP = AW'(1) << QW_BYTES_LOG2;

  function automatic logic [AW-1:0] foldRing(input logic [AW-1:0] a,
                                             input logic [AW-1:0] base,
                                             input logic [AW-1:0] mask);
    return base + (a & mask);
  endfunction

  logic          inRing;
  logic          irqEnR;
  logic [2:0]    kind;
  logic [QCW-1:0] tagQwc;
  logic [AW-1:0] addrField;
  logic [AW-1:0] tagPlus;
  logic [AW-1:0] afterData;
  logic [AW-1:0] nData, nTag;
  logic [QCW-1:0] nQwc;
  logic          nEnd, nRing;
  logic [QCW-1:0] takeAmt;
  logic [AW-1:0] advAddr;
  logic [AW-1:0] ringEnd;
  logic [AW-1:0] room;

  assign kind      = tagWord0[30:28];
  assign tagQwc    = tagWord0[QCW-1:0];
  assign addrField = tagWord1[AW-1:0];
  assign tagPlus   = foldRing(tagAddr + QW_STEP, ringBase, ringMask);
  assign afterData = foldRing(tagPlus + (AW'(tagQwc) << QW_BYTES_LOG2), ringBase, ringMask);

  always_comb begin
    nData = dataAddr;
    nTag  = tagAddr;
    nQwc  = tagQwc;
    nEnd  = 1'b0;
    nRing = 1'b0;
    unique case (kind)
      KIND_REFE: begin
        nData = addrField; nTag = tagPlus; nEnd = 1'b1;
      end
      KIND_CNT: begin
        nData = tagPlus; nTag = afterData; nRing = 1'b1;
      end
      KIND_NEXT: begin
        nData = tagPlus; nTag = addrField; nRing = 1'b1;
      end
      KIND_REF, KIND_REFS: begin
        nData = addrField; nTag = tagPlus;
      end
      KIND_END: begin
        nData = tagPlus; nTag = afterData; nRing = 1'b1; nEnd = 1'b1;
      end
      default: begin
        nQwc = '0; nEnd = 1'b1;
      end
    endcase
    if (tagWord0[31] && irqEnR) nEnd = 1'b1;
  end

  assign takeAmt = (consumeQwc > dataQwc) ? dataQwc : consumeQwc;
  assign advAddr = dataAddr + (AW'(takeAmt) << QW_BYTES_LOG2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagAddr    <= '0;
      dataAddr   <= '0;
      dataQwc    <= '0;
      ctrlUpper  <= '0;
      endPending <= 1'b0;
      inRing     <= 1'b0;
      irqEnR     <= 1'b0;
    end else if (stb.loadStart) begin
      tagAddr    <= startTagAddr;
      dataQwc    <= '0;
      endPending <= 1'b0;
      inRing     <= 1'b0;
      irqEnR     <= tagIrqEn;
    end else if (stb.takeTag) begin
      tagAddr    <= nTag;
      dataAddr   <= nData;
      dataQwc    <= nQwc;
      ctrlUpper  <= tagWord0[31:16];
      endPending <= nEnd;
      inRing     <= nRing;
    end else if (stb.takeData) begin
      dataQwc  <= dataQwc - takeAmt;
      dataAddr <= inRing ? foldRing(advAddr, ringBase, ringMask) : advAddr;
    end
  end

  // credit counter
  logic signed [AVW-1:0] creditNext;
  always_comb begin
    creditNext = availQwc;
    if (addValid)     creditNext = creditNext + AVW'(addQwc);
    if (stb.takeTag)  creditNext = creditNext - AVW'(1);
    if (stb.takeData) creditNext = creditNext - AVW'(takeAmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           availQwc <= '0;
    else if (stb.finish) availQwc <= '0;
    else                 availQwc <= creditNext;
  end

  assign availPos = (availQwc > 0);
  assign qwcZero  = (dataQwc == '0);

  // segment before ring end
  assign ringEnd = ringBase + ringMask + AW'(1);
  assign room    = (ringEnd - dataAddr) >> QW_BYTES_LOG2;
  assign segQwc  = (inRing && (room < AW'(dataQwc))) ? room[QCW-1:0] : dataQwc;
endmodule

// File: rtl/ring_walk_ctl.sv
module ring_walk_ctl
  import ring_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        tagValid,
  input  logic        consumeValid,
  input  logic        availPos,
  input  logic        qwcZero,
  input  logic        endPending,
  output walkStrobe_t stb,
  output logic        tagReq,
  output logic        stallIrq,
  output logic        done,
  output logic        active
);
  walkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    tagReq    = 1'b0;
    stallIrq  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.loadStart = 1'b1;
          stateNext     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (!availPos) begin
          stallIrq  = 1'b1;
          stateNext = ST_STALL;
        end else begin
          tagReq = 1'b1;
          if (tagValid) begin
            stb.takeTag = 1'b1;
            stateNext   = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (qwcZero) begin
          if (endPending) begin
            done       = 1'b1;
            stb.finish = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            stateNext = ST_FETCH;
          end
        end else if (consumeValid) begin
          stb.takeData = 1'b1;
        end
      end
      ST_STALL: begin
        if (availPos) stateNext = ST_FETCH;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign active = (state != ST_IDLE);
endmodule

// File: rtl/ring_chain_walker.sv
module ring_chain_walker
  import ring_walk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int QCW = 16,
  parameter int AVW = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [AW-1:0]         ringBase,
  input  logic [AW-1:0]         ringMask,
  input  logic                  start,
  input  logic [AW-1:0]         startTagAddr,
  input  logic                  tagIrqEn,
  input  logic                  addValid,
  input  logic [QCW-1:0]        addQwc,
  input  logic                  consumeValid,
  input  logic [QCW-1:0]        consumeQwc,
  output logic                  tagReq,
  output logic [AW-1:0]         tagAddr,
  input  logic                  tagValid,
  input  logic [31:0]           tagWord0,
  input  logic [31:0]           tagWord1,
  output logic [AW-1:0]         dataAddr,
  output logic [QCW-1:0]        dataQwc,
  output logic [QCW-1:0]        segQwc,
  output logic [15:0]           ctrlUpper,
  output logic signed [AVW-1:0] availQwc,
  output logic                  active,
  output logic                  done,
  output logic                  stallIrq
);
  walkStrobe_t stb;
  logic availPos, qwcZero, endPending;

  ring_walk_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .tagValid(tagValid),
    .consumeValid(consumeValid), .availPos(availPos), .qwcZero(qwcZero),
    .endPending(endPending), .stb(stb), .tagReq(tagReq),
    .stallIrq(stallIrq), .done(done), .active(active)
  );

  ring_walk_dp #(.AW(AW), .QCW(QCW), .AVW(AVW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ringBase(ringBase),
    .ringMask(ringMask), .startTagAddr(startTagAddr), .tagIrqEn(tagIrqEn),
    .tagWord0(tagWord0), .tagWord1(tagWord1), .addValid(addValid),
    .addQwc(addQwc), .consumeQwc(consumeQwc), .tagAddr(tagAddr),
    .dataAddr(dataAddr), .dataQwc(dataQwc), .segQwc(segQwc),
    .ctrlUpper(ctrlUpper), .availQwc(availQwc), .availPos(availPos),
    .qwcZero(qwcZero), .endPending(endPending)
  );
endmodule

// File: rtl/ring_walk_chk.sv
module ring_walk_chk #(
  parameter int QCW = 16,
  parameter int AVW = 24
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  tagReq,
  input logic                  tagValid,
  input logic [QCW-1:0]        dataQwc,
  input logic [QCW-1:0]        segQwc,
  input logic signed [AVW-1:0] availQwc,
  input logic                  active,
  input logic                  done,
  input logic                  stallIrq
);
  a_r10_stall_no_fetch: assert property (@(posedge clk) disable iff (!rstN)
    stallIrq |-> !tagReq);
  a_r10_fetch_needs_credit: assert property (@(posedge clk) disable iff (!rstN)
    tagReq |-> (availQwc > 0));
  a_r10_stall_single: assert property (@(posedge clk) disable iff (!rstN)
    stallIrq |=> !stallIrq);
  a_r11_done_drained: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (dataQwc == '0));
  a_r11_done_idles: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!active && availQwc == 0));
  a_r2_one_tag_per_req: assert property (@(posedge clk) disable iff (!rstN)
    (tagReq && tagValid) |=> !tagReq);
  a_r12_seg_bounded: assert property (@(posedge clk) disable iff (!rstN)
    segQwc <= dataQwc);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!tagReq && !stallIrq && !done));
endmodule

bind ring_chain_walker ring_walk_chk #(.QCW(QCW), .AVW(AVW)) u_chk (
  .clk(clk), .rstN(rstN), .tagReq(tagReq), .tagValid(tagValid),
  .dataQwc(dataQwc), .segQwc(segQwc), .availQwc(availQwc),
  .active(active), .done(done), .stallIrq(stallIrq)
);

// File: tb/ring_chain_walker_bench.sv
module ring_chain_walker_bench;
  localparam int AW = 32, QCW = 16, AVW = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] ringBase = 32'h1000;
  logic [AW-1:0] ringMask = 32'h00FF;
  logic start = 0, tagIrqEn = 0, addValid = 0, consumeValid = 0, tagValid = 0;
  logic [AW-1:0] startTagAddr = '0;
  logic [QCW-1:0] addQwc = '0, consumeQwc = '0;
  logic [31:0] tagWord0 = '0, tagWord1 = '0;
  logic tagReq, active, done, stallIrq;
  logic [AW-1:0] tagAddr, dataAddr;
  logic [QCW-1:0] dataQwc, segQwc;
  logic [15:0] ctrlUpper;
  logic signed [AVW-1:0] availQwc;

  int checks = 0, errors = 0;
  logic [AW-1:0] fetchQ[$];

  always #4 clk = ~clk;

  ring_chain_walker #(.AW(AW), .QCW(QCW), .AVW(AVW)) u_ring_chain_walker (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .ringMask(ringMask),
    .start(start), .startTagAddr(startTagAddr), .tagIrqEn(tagIrqEn),
    .addValid(addValid), .addQwc(addQwc), .consumeValid(consumeValid),
    .consumeQwc(consumeQwc), .tagReq(tagReq), .tagAddr(tagAddr),
    .tagValid(tagValid), .tagWord0(tagWord0), .tagWord1(tagWord1),
    .dataAddr(dataAddr), .dataQwc(dataQwc), .segQwc(segQwc),
    .ctrlUpper(ctrlUpper), .availQwc(availQwc), .active(active),
    .done(done), .stallIrq(stallIrq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares each new fetch address against the scoreboard
  logic prevReq = 1'b0;
  always @(negedge clk) begin
    if (rstN && tagReq && !prevReq) begin
      if (fetchQ.size() == 0) check("R3 unexpected fetch", longint'(tagAddr), 0);
      else check("R3 fetch address", longint'(tagAddr), longint'(fetchQ.pop_front()));
    end
    prevReq = tagReq;
  end

  task automatic expectFetch(input logic [AW-1:0] a);
    fetchQ.push_back(a);
  endtask

  task automatic addCredit(input int n);
    addValid = 1; addQwc = QCW'(n);
    @(negedge clk);
    addValid = 0;
  endtask

  task automatic startChain(input logic [AW-1:0] a, input logic en);
    expectFetch(a);
    start = 1; startTagAddr = a; tagIrqEn = en;
    @(negedge clk);
    start = 0;
  endtask

  task automatic serveTag(input logic [31:0] w0, input logic [31:0] w1);
    for (int k = 0; k < 100 && !tagReq; k++) @(negedge clk);
    check("R2 tag request seen", longint'(tagReq), 1);
    tagValid = 1; tagWord0 = w0; tagWord1 = w1;
    @(negedge clk);
    tagValid = 0;
  endtask

  task automatic consume(input int n);
    consumeValid = 1; consumeQwc = QCW'(n);
    @(negedge clk);
    consumeValid = 0;
  endtask

  task automatic waitDone(input string req);
    for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    check(req, longint'(done), 1);
    @(negedge clk);
    check({req, " inactive after"}, longint'(active), 0);
    check({req, " credit cleared"}, longint'(availQwc), 0);
  endtask

  task automatic waitStall(input string req);
    for (int k = 0; k < 100 && !stallIrq; k++) @(negedge clk);
    check(req, longint'(stallIrq), 1);
    check({req, " no request"}, longint'(tagReq), 0);
    @(negedge clk);
    check({req, " one-cycle pulse"}, longint'(stallIrq), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 active", longint'(active), 0);
    check("R1 tagReq", longint'(tagReq), 0);
    check("R1 credit", longint'(availQwc), 0);
    check("R1 dataQwc", longint'(dataQwc), 0);
    check("R1 done/stall", longint'({done, stallIrq}), 0);

    // chain 1
    addCredit(10);
    check("R9 credit add", longint'(availQwc), 10);
    startChain(32'h1000, 1'b0);
    serveTag(32'h1ABC_0003, 32'h0);           // cnt, 3 qw
    check("R5 cnt data", longint'(dataAddr), 32'h1010);
    check("R5 cnt next tag", longint'(tagAddr), 32'h1040);
    check("R2 count field", longint'(dataQwc), 3);
    check("R2 upper copy", longint'(ctrlUpper), 16'h1ABC);
    check("R9 tag cost", longint'(availQwc), 9);
    check("R12 seg no wrap", longint'(segQwc), 3);
    expectFetch(32'h1040);
    consume(2);
    check("R14 count down", longint'(dataQwc), 1);
    check("R14 addr advance", longint'(dataAddr), 32'h1030);
    check("R9 consume cost", longint'(availQwc), 7);
    consume(1);
    serveTag(32'h2000_0002, 32'h10E0);        // next
    check("R6 next data", longint'(dataAddr), 32'h1050);
    check("R6 next tag", longint'(tagAddr), 32'h10E0);
    expectFetch(32'h10E0);
    consume(2);
    serveTag(32'h1000_0004, 32'h0);           // cnt near ring end
    check("R3 fold data", longint'(dataAddr), 32'h10F0);
    check("R3 fold next tag", longint'(tagAddr), 32'h1030);
    check("R12 seg split", longint'(segQwc), 1);
    check("R9 credit", longint'(availQwc), 2);
    consume(1);
    check("R12 wrap to base", longint'(dataAddr), 32'h1000);
    check("R12 seg after wrap", longint'(segQwc), 3);
    consume(3);
    check("R9 negative credit", longint'(availQwc), -2);
    waitStall("R10 stall on empty");
    expectFetch(32'h1030);
    addCredit(5);
    serveTag(32'h3000_0002, 32'h8000);        // ref
    check("R7 ref data", longint'(dataAddr), 32'h8000);
    check("R7 ref next tag", longint'(tagAddr), 32'h1040);
    check("R12 seg outside ring", longint'(segQwc), 2);
    consume(2);
    check("R7 no fold outside ring", longint'(dataAddr), 32'h8020);
    waitStall("R10 stall at zero credit");
    expectFetch(32'h1040);
    addCredit(4);
    serveTag(32'h4000_0001, 32'h9000);        // refs
    check("R7 refs data", longint'(dataAddr), 32'h9000);
    check("R7 refs next tag", longint'(tagAddr), 32'h1050);
    expectFetch(32'h1050);
    consume(1);
    serveTag(32'h7000_0001, 32'h0);           // end
    check("R5 end data", longint'(dataAddr), 32'h1060);
    check("R5 end next tag", longint'(tagAddr), 32'h1070);
    consume(1);
    waitDone("R11 end tag done");

    // chain 2: refe at ring end
    addCredit(3);
    startChain(32'h10F0, 1'b1);
    serveTag(32'h0000_0002, 32'hA000);
    check("R4 refe data", longint'(dataAddr), 32'hA000);
    check("R4 refe next tag", longint'(tagAddr), 32'h1000);
    consume(2);
    waitDone("R4 refe ends chain");

    // chain 3: bit 31 with enable
    addCredit(3);
    startChain(32'h1020, 1'b1);
    serveTag(32'h9000_0001, 32'h0);
    check("R8 upper copy", longint'(ctrlUpper), 16'h9000);
    consume(1);
    waitDone("R8 flag ends chain");

    // chain 4: bit 31 without enable, then type 5
    addCredit(4);
    startChain(32'h1020, 1'b0);
    serveTag(32'h9000_0001, 32'h0);
    expectFetch(32'h1040);
    consume(1);
    for (int k = 0; k < 20 && !tagReq; k++) @(negedge clk);
    check("R8 flag ignored, continues", longint'(tagReq), 1);
    serveTag(32'h5000_0007, 32'hB000);
    check("R13 odd type zero count", longint'(dataQwc), 0);
    check("R13 odd type keeps tag", longint'(tagAddr), 32'h1040);
    check("R13 odd type done", longint'(done), 1);
    @(negedge clk);
    check("R11 inactive", longint'(active), 0);
    check("R11 credit cleared", longint'(availQwc), 0);

    check("R3 scoreboard drained", longint'(fetchQ.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule